// File: doc/BRIEF.md
# Page Aging Replacement Engine

The engine keeps a recency score for each of a fixed set of page slots and names the slot that makes the best eviction candidate. Every slot holds a small score counter and a referenced flag. Memory references to a slot set its flag. A built-in divider fires a periodic update that folds every flag into its counter in the same cycle and then clears the flags. Loading a new page into a slot resets that slot's state.

Two update rules are available. In the aging rule, each counter moves right by one bit and the flag enters at the top, so recent references outweigh older ones. In the counting rule, the flag is added to the counter, which saturates at all ones. The slot with the smallest counter is reported combinationally as the victim, together with its score. A probe port reads back one chosen slot's counter and flag.

Top module: `page_age_engine`

## Requirements
- R1: After reset every counter and every referenced flag is zero, the reported victim is slot 0 and the victim score is 0.
- R2: A reference strobe to an in-range slot sets that slot's flag at the next clock edge. A reference to an index of NUM_ENT or above changes nothing.
- R3: The periodic update is applied at clock edge number TICK_DIV after reset release, and at every TICK_DIV-th edge after that. Between updates no counter changes except through a load.
- R4: With mode_sel = 0 (aging), an update sets each counter to {flag, counter[W-1:1]}. For example, 8-bit 10000000 with the flag clear becomes 01000000, and then becomes 10100000 after an update with the flag set.
- R5: An update clears every flag. A reference that arrives in the same cycle as an update leaves that slot's flag set afterwards.
- R6: With mode_sel = 1 (counting), an update adds the flag (0 or 1) to each counter and holds it at all ones instead of wrapping.
- R7: A load strobe to a slot sets that slot's counter to zero and clears its flag. The load wins over an update in the same cycle. A reference to the same slot in that cycle leaves the flag set.
- R8: victim_idx names the slot with the smallest counter, with ties going to the lowest index. victim_cnt equals that counter's value.
- R9: victim_valid is 1 whenever reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | 0 = aging shift rule, 1 = saturating count rule |
| ref_valid | input | 1 | Reference strobe |
| ref_idx | input | IDX_W | Slot being referenced |
| ld_valid | input | 1 | Load strobe |
| ld_idx | input | IDX_W | Slot receiving a new page |
| probe_idx | input | IDX_W | Slot to read back |
| probe_cnt | output | CNT_W | Counter of the probed slot (0 if out of range) |
| probe_ref | output | 1 | Flag of the probed slot (0 if out of range) |
| victim_valid | output | 1 | Victim output is meaningful |
| victim_idx | output | IDX_W | Slot with the lowest counter |
| victim_cnt | output | CNT_W | Counter value of that slot |

## Verification
A corrupted counter or a lost flag shows up on probe_cnt at the first update after the fault. It shows up on victim_idx and victim_cnt as soon as the bad value becomes, or stops being, the minimum. A divider that runs off its period moves the edge at which all counters change, so the error is visible within one update period. The bench probes a changing slot and compares the victim and the probe against a behavioural model on every cycle. Any error is therefore reported in the cycle it first reaches a port.

// File: rtl/page_age_pkg.sv
package page_age_pkg;
  typedef enum logic {
    UPD_SHIFT = 1'b0,
    UPD_COUNT = 1'b1
  } upd_mode_e;
endpackage

// File: rtl/page_age_divider.sv
module page_age_divider #(
  parameter int TICK_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic             div_en;

  assign tick = (div_q == LAST);

  always_comb begin
    div_en = 1'b1;
    div_d  = tick ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_en) div_q <= div_d;
  end
endmodule

// File: rtl/page_age_entry.sv
module page_age_entry
  import page_age_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  upd_mode_e        mode,
  input  logic             ref_hit,
  input  logic             ld_hit,
  output logic [CNT_W-1:0] cnt_q,
  output logic             r_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             r_d;
  logic             r_en;

  always_comb begin
    cnt_en = ld_hit | tick;
    cnt_d  = cnt_q;
    if (ld_hit) begin
      cnt_d = '0;
    end else if (tick) begin
      if (mode == UPD_SHIFT) begin
        cnt_d = {r_q, cnt_q[CNT_W-1:1]};
      end else if (r_q && (cnt_q != CNT_MAX)) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    r_en = ref_hit | ld_hit | tick;
    r_d  = ref_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    r_q <= 1'b0;
    else if (r_en) r_q <= r_d;
  end
endmodule

// File: rtl/page_age_minsel.sv
module page_age_minsel #(
  parameter int NUM_ENT = 8,
  parameter int CNT_W   = 8,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_ENT-1:0][CNT_W-1:0] cnt,
  output logic [IDX_W-1:0]              min_idx,
  output logic [CNT_W-1:0]              min_cnt
);
  always_comb begin
    min_idx = '0;
    min_cnt = cnt[0];
    for (int i = 1; i < NUM_ENT; i++) begin
      if (cnt[i] < min_cnt) begin
        min_cnt = cnt[i];
        min_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/page_age_engine.sv
module page_age_engine
  import page_age_pkg::*;
#(
  parameter int NUM_ENT  = 8,
  parameter int CNT_W    = 8,
  parameter int TICK_DIV = 16,
  parameter int IDX_W    = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_sel,
  input  logic             ref_valid,
  input  logic [IDX_W-1:0] ref_idx,
  input  logic             ld_valid,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [IDX_W-1:0] probe_idx,
  output logic [CNT_W-1:0] probe_cnt,
  output logic             probe_ref,
  output logic             victim_valid,
  output logic [IDX_W-1:0] victim_idx,
  output logic [CNT_W-1:0] victim_cnt
);
  logic                          age_tick;
  logic [NUM_ENT-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_ENT-1:0]            r_q;
  logic [NUM_ENT-1:0]            ref_hit;
  logic [NUM_ENT-1:0]            ld_hit;
  upd_mode_e                     mode;

  assign mode = upd_mode_e'(mode_sel);

  page_age_divider #(.TICK_DIV(TICK_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (age_tick)
  );

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    assign ref_hit[g] = ref_valid && (ref_idx == IDX_W'(g));
    assign ld_hit[g]  = ld_valid  && (ld_idx  == IDX_W'(g));

    page_age_entry #(.CNT_W(CNT_W)) u_ent (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (age_tick),
      .mode    (mode),
      .ref_hit (ref_hit[g]),
      .ld_hit  (ld_hit[g]),
      .cnt_q   (cnt_q[g]),
      .r_q     (r_q[g])
    );
  end

  page_age_minsel #(.NUM_ENT(NUM_ENT), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_min (
    .cnt     (cnt_q),
    .min_idx (victim_idx),
    .min_cnt (victim_cnt)
  );

  assign victim_valid = (NUM_ENT >= 1);

  always_comb begin
    probe_cnt = '0;
    probe_ref = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (probe_idx == IDX_W'(i)) begin
        probe_cnt = cnt_q[i];
        probe_ref = r_q[i];
      end
    end
  end
endmodule

// File: rtl/page_age_engine_chk.sv
module page_age_engine_chk #(
  parameter int NUM_ENT  = 8,
  parameter int CNT_W    = 8,
  parameter int TICK_DIV = 16,
  parameter int IDX_W    = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          mode_sel,
  input logic                          ref_valid,
  input logic [IDX_W-1:0]              ref_idx,
  input logic                          ld_valid,
  input logic [IDX_W-1:0]              ld_idx,
  input logic [IDX_W-1:0]              victim_idx,
  input logic [CNT_W-1:0]              victim_cnt,
  input logic                          age_tick,
  input logic [NUM_ENT-1:0][CNT_W-1:0] cnt_q,
  input logic [NUM_ENT-1:0]            r_q
);
  localparam logic [IDX_W:0] ENT_CNT = (IDX_W+1)'(NUM_ENT);
  localparam int             GAP_W   = $clog2(TICK_DIV + 1);

  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gap_q <= '0;
    else if (age_tick) gap_q <= '0;
    else               gap_q <= gap_q + 1'b1;
  end

  // R3
  tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    age_tick |-> (gap_q == GAP_W'(TICK_DIV - 1)));

  // R2
  ref_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && ({1'b0, ref_idx} < ENT_CNT)) |=> r_q[$past(ref_idx)]);

  // R7
  load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ({1'b0, ld_idx} < ENT_CNT)) |=> (cnt_q[$past(ld_idx)] == '0));

  // R5
  tick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_tick && !ref_valid) |=> (r_q == '0));

  // R8
  victim_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q[victim_idx] == victim_cnt);

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_chk
    // R8
    victim_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[g] >= victim_cnt);

    // R6
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel && age_tick && (cnt_q[g] == '1) &&
       !(ld_valid && (ld_idx == IDX_W'(g)))) |=> (cnt_q[g] == '1));
  end
endmodule

bind page_age_engine page_age_engine_chk #(
  .NUM_ENT(NUM_ENT), .CNT_W(CNT_W), .TICK_DIV(TICK_DIV), .IDX_W(IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_sel   (mode_sel),
  .ref_valid  (ref_valid),
  .ref_idx    (ref_idx),
  .ld_valid   (ld_valid),
  .ld_idx     (ld_idx),
  .victim_idx (victim_idx),
  .victim_cnt (victim_cnt),
  .age_tick   (age_tick),
  .cnt_q      (cnt_q),
  .r_q        (r_q)
);

// File: tb/page_age_engine_tb.sv
`timescale 1ns/1ps
module page_age_engine_tb;
  localparam int NE = 5;
  localparam int CW = 4;
  localparam int KD = 4;
  localparam int IW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode_sel;
  logic          ref_valid;
  logic [IW-1:0] ref_idx;
  logic          ld_valid;
  logic [IW-1:0] ld_idx;
  logic [IW-1:0] probe_idx;
  logic [CW-1:0] probe_cnt;
  logic          probe_ref;
  logic          victim_valid;
  logic [IW-1:0] victim_idx;
  logic [CW-1:0] victim_cnt;

  always #2 clk = ~clk;

  page_age_engine #(.NUM_ENT(NE), .CNT_W(CW), .TICK_DIV(KD), .IDX_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .ref_valid(ref_valid), .ref_idx(ref_idx),
    .ld_valid(ld_valid), .ld_idx(ld_idx),
    .probe_idx(probe_idx), .probe_cnt(probe_cnt), .probe_ref(probe_ref),
    .victim_valid(victim_valid), .victim_idx(victim_idx), .victim_cnt(victim_cnt)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  int    m_cnt[NE];
  bit    m_r[NE];
  int    m_div;
  string cnt_tag = "R1";
  string ref_tag = "R1";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    int bi = 0;
    int pc = 0;
    int pr = 0;
    for (int i = 1; i < NE; i++) if (m_cnt[i] < m_cnt[bi]) bi = i;
    chk(victim_valid === 1'b1, "R9", int'(victim_valid), 1);
    chk(int'(victim_idx) == bi, "R8", int'(victim_idx), bi);
    chk(int'(victim_cnt) == m_cnt[bi], "R8", int'(victim_cnt), m_cnt[bi]);
    if (int'(probe_idx) < NE) begin
      pc = m_cnt[probe_idx];
      pr = int'(m_r[probe_idx]);
    end
    chk(int'(probe_cnt) == pc, cnt_tag, int'(probe_cnt), pc);
    chk(int'(probe_ref) == pr, ref_tag, int'(probe_ref), pr);
  endtask

  task automatic model_step();
    bit tk = (m_div == KD - 1);
    int p  = int'(probe_idx);
    bit rh, lh;
    m_div = tk ? 0 : m_div + 1;
    cnt_tag = "R3";
    ref_tag = "R2";
    for (int i = 0; i < NE; i++) begin
      rh = ref_valid && (int'(ref_idx) == i);
      lh = ld_valid && (int'(ld_idx) == i);
      if (lh) begin
        m_cnt[i] = 0;
        m_r[i]   = rh;
        if (i == p) begin cnt_tag = "R7"; ref_tag = "R7"; end
      end else if (tk) begin
        if (!mode_sel) m_cnt[i] = (m_cnt[i] >> 1) | (int'(m_r[i]) << (CW - 1));
        else if (m_r[i] && m_cnt[i] < CMAX) m_cnt[i] = m_cnt[i] + 1;
        m_r[i] = rh;
        if (i == p) begin cnt_tag = mode_sel ? "R6" : "R4"; ref_tag = "R5"; end
      end else begin
        m_r[i] = m_r[i] | rh;
      end
    end
  endtask

  task automatic cyc(input bit rv, input int ri, input bit lv, input int li,
                     input bit md, input int pi);
    compare();
    ref_valid = rv; ref_idx = IW'(ri);
    ld_valid  = lv; ld_idx  = IW'(li);
    mode_sel  = md; probe_idx = IW'(pi);
    model_step();
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; mode_sel = 1'b0; ref_valid = 1'b0; ref_idx = '0;
    ld_valid = 1'b0; ld_idx = '0; probe_idx = '0;
    for (int i = 0; i < NE; i++) begin m_cnt[i] = 0; m_r[i] = 0; end
    m_div = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(victim_idx == '0, "R1", int'(victim_idx), 0);
    chk(victim_cnt == '0, "R1", int'(victim_cnt), 0);
    chk(probe_cnt == '0 && probe_ref == 1'b0, "R1", int'(probe_cnt), 0);
    rst_n = 1'b1;

    // R4 worked example on slot 3: reference, age twice, reference, age
    cyc(1, 3, 0, 0, 0, 3);
    for (int c = 0; c < KD; c++) cyc(0, 0, 0, 0, 0, 3);
    for (int c = 0; c < KD; c++) cyc(0, 0, 0, 0, 0, 3);
    cyc(1, 3, 0, 0, 0, 3);
    for (int c = 0; c < KD; c++) cyc(0, 0, 0, 0, 0, 3);

    // R4 R2 R5 R7 random traffic in aging mode, including out-of-range indices
    for (int c = 0; c < 400; c++)
      cyc($urandom_range(0, 2) != 0, $urandom_range(0, 7),
          $urandom_range(0, 9) == 0, $urandom_range(0, 7), 0, $urandom_range(0, 5));

    // R6 saturation: keep referencing slot 1 in counting mode
    for (int c = 0; c < 90; c++) cyc(1, 1, 0, 0, 1, 1);
    for (int c = 0; c < 300; c++)
      cyc($urandom_range(0, 1) != 0, $urandom_range(0, 7),
          $urandom_range(0, 11) == 0, $urandom_range(0, 7), 1, $urandom_range(0, 5));

    // R8 ties: load every slot, then lift slot 0 above the rest
    for (int i = 0; i < NE; i++) cyc(0, 0, 1, i, 0, i);
    for (int c = 0; c < 2 * KD; c++) cyc(c == 0, 0, 0, 0, 0, 0);

    // R7 load colliding with reference and update
    for (int c = 0; c < 3 * KD; c++) cyc(1, 2, 1, 2, c[0], 2);
    for (int c = 0; c < KD; c++) cyc(0, 0, 0, 0, 0, 2);

    compare();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule